// File: doc/BRIEF.md
# Programmable Target-Compare Timer

A 16-bit up-counter with a compare register and a control/status word. Software reaches three registers through a simple single-cycle register bus: the live count, the mode word and the target. On each enabled tick the count advances by one. Depending on the mode, the count either returns to zero when it reaches the target or runs to 0xFFFF and wraps. Either event can raise a one-clock interrupt pulse, in a one-shot or a repeating form. Sticky status bits in the mode word record which events have occurred.

The tick comes from the system clock or from a source that depends on the instance. `INST_SEL` 0 and 1 take an external tick input (for example a pixel-rate or line-rate strobe). `INST_SEL` 2 instead offers an internal divide-by-8 prescaler and a stop control. A write to the mode word restarts the counter and re-arms the one-shot interrupt.

Register addresses: 0 is the count, 1 is the mode word, 2 is the target, and 3 reads as zero.

Mode bits:
- 0: stop (instance 2)
- 3: reset at target
- 4: interrupt on target
- 5: interrupt on overflow
- 6: repeat
- 8: alternate tick (instances 0 and 1)
- 9: divide-by-8 (instance 2)
- 10: any-event flag
- 11: target-reached flag
- 12: overflow flag

Top module: `tgt_timer`

## Requirements
- R1: A write to address 0 loads the count with the low 16 bits of the write data on that clock edge. Counting resumes from that value, and no event is produced on the load edge.
- R2: With mode bit 3 set, a tick that would bring the count to the target value sets the count to 0 instead. The period is therefore target ticks.
- R3: With mode bit 3 clear, the count runs past the target to 0xFFFF and then wraps to 0. The wrap is the overflow event.
- R4: Mode bit 4 enables an interrupt on the target event and mode bit 5 enables one on overflow. irq_o is high for exactly the clock that follows the edge on which the event occurred.
- R5: With mode bit 6 set, every enabled event pulses irq_o. With bit 6 clear, only the first event pulses, until the mode word is written again.
- R6: A write to address 1 sets the count and the prescaler to 0 and stores data bits 9..0. Bits 15..10 become 0. No event is produced on that edge.
- R7: The target event sets mode bit 11 and the overflow event sets mode bit 12. A read of address 1 returns the current word, and on that edge clears bits 11 and 12. An event on the same edge takes precedence over the clear.
- R8: Mode bit 10 is set by any target or overflow event. A read does not clear it.
- R9: In instances 0 and 1, mode bit 8 makes the count advance only on alt_tick_i. In instance 2, bit 9 makes it advance once every 8 clocks, with the first advance on the 8th edge after a mode write. In instance 2, bit 0 stops counting.
- R10: A write to address 2 changes the target only. The count keeps advancing as if no write had happened.
- R11: When target 0 coincides with the wrap, both bits 11 and 12 are set and irq_o pulses only once.
- R12: After reset the count, mode and target read as 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (clears mode flags on address 1) |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational from the address |
| alt_tick_i | input | 1 | External tick enable (instances 0 and 1) |
| irq_o | output | 1 | Interrupt pulse |

## Verification
Two functions can fall on the same edge. One is a status-flag clear caused by a mode read. The other is a target event that sets the flag.

The bench provokes this collision on purpose. It starts a reset-at-target period of 10 and holds the read strobe across exactly the edge on which the count reaches the target. The value returned by that read must be clean. The next read must show the flag set, because the event wins, and the read after that must show it cleared.

A second collision uses target 0, so that the target event lands on the overflow wrap. The bench judges it by counting irq_o pulses in a fixed window and by reading both flags back.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int MODE_W = 16;
  localparam int KEEP_W = 10;  // writable mode bits

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_TGT  = 2'd2;

  localparam int MB_STOP    = 0;
  localparam int MB_RST_TGT = 3;
  localparam int MB_IRQ_TGT = 4;
  localparam int MB_IRQ_OVF = 5;
  localparam int MB_RPT     = 6;
  localparam int MB_ALT     = 8;
  localparam int MB_DIV8    = 9;
  localparam int MB_EVT     = 10;
  localparam int MB_HIT_TGT = 11;
  localparam int MB_HIT_OVF = 12;

  typedef struct packed {
    logic tgt;
    logic ovf;
  } evt_t;
endpackage

// File: rtl/tmr_tick_sel.sv
`timescale 1ns/1ps
module tmr_tick_sel #(
  parameter int INST_SEL = 2,
  parameter int PRE_W    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic stop_i,
  input  logic div8_i,
  input  logic alt_sel_i,
  input  logic alt_tick_i,
  output logic tick_o
);
  generate
    if (INST_SEL == 2) begin : g_presc
      logic [PRE_W-1:0] pre_q;
      logic unused_alt;
      assign unused_alt = alt_sel_i ^ alt_tick_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    pre_q <= '0;
        else if (clr_i) pre_q <= '0;
        else            pre_q <= pre_q + 1'b1;
      end

      assign tick_o = !stop_i && (div8_i ? (&pre_q) : 1'b1);
    end else begin : g_alt
      logic unused_pre;
      assign unused_pre = ^{clk_i, rst_ni, clr_i, stop_i, div8_i};
      assign tick_o = alt_sel_i ? alt_tick_i : 1'b1;
    end
  endgenerate
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core import tmr_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             rst_at_tgt_i,
  input  logic [CNT_W-1:0] target_i,
  output logic [CNT_W-1:0] cnt_o,
  output evt_t             evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   nxt;
  logic             adv;

  assign nxt       = {1'b0, cnt_q} + 1'b1;
  assign adv       = tick_i && !clr_i && !ld_i;
  assign evt_o.tgt = adv && (nxt[CNT_W-1:0] == target_i);
  assign evt_o.ovf = adv && nxt[CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (ld_i)                       cnt_q <= ld_val_i;
    else if (evt_o.tgt && rst_at_tgt_i)  cnt_q <= '0;
    else if (adv)                        cnt_q <= nxt[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_irq.sv
`timescale 1ns/1ps
module tmr_irq import tmr_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rearm_i,
  input  evt_t evt_i,
  input  logic en_tgt_i,
  input  logic en_ovf_i,
  input  logic rpt_i,
  output logic irq_o
);
  logic armed_q, irq_q, want, fire;

  assign want = (evt_i.tgt && en_tgt_i) || (evt_i.ovf && en_ovf_i);
  assign fire = want && (rpt_i || armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= fire;
      if (rearm_i)             armed_q <= 1'b1;
      else if (fire && !rpt_i) armed_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/tgt_timer.sv
`timescale 1ns/1ps
module tgt_timer import tmr_pkg::*; #(
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 32,
  parameter int PRE_W    = 3,
  parameter int INST_SEL = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              alt_tick_i,
  output logic              irq_o
);
  logic [MODE_W-1:0] mode_q, mode_nxt;
  logic [CNT_W-1:0]  tgt_q, cnt_q;
  logic              wr_cnt, wr_mode, wr_tgt, rd_mode, tick;
  evt_t              evt;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:CNT_W];
  assign wr_cnt  = bus_we_i && (bus_addr_i == ADDR_CNT);
  assign wr_mode = bus_we_i && (bus_addr_i == ADDR_MODE);
  assign wr_tgt  = bus_we_i && (bus_addr_i == ADDR_TGT);
  assign rd_mode = bus_re_i && (bus_addr_i == ADDR_MODE);

  tmr_tick_sel #(.INST_SEL(INST_SEL), .PRE_W(PRE_W)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (wr_mode),
    .stop_i     (mode_q[MB_STOP]),
    .div8_i     (mode_q[MB_DIV8]),
    .alt_sel_i  (mode_q[MB_ALT]),
    .alt_tick_i (alt_tick_i),
    .tick_o     (tick)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .clr_i        (wr_mode),
    .ld_i         (wr_cnt),
    .ld_val_i     (bus_wdata_i[CNT_W-1:0]),
    .rst_at_tgt_i (mode_q[MB_RST_TGT]),
    .target_i     (tgt_q),
    .cnt_o        (cnt_q),
    .evt_o        (evt)
  );

  tmr_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rearm_i  (wr_mode),
    .evt_i    (evt),
    .en_tgt_i (mode_q[MB_IRQ_TGT]),
    .en_ovf_i (mode_q[MB_IRQ_OVF]),
    .rpt_i    (mode_q[MB_RPT]),
    .irq_o    (irq_o)
  );

  // event set wins over read clear
  always_comb begin
    mode_nxt = mode_q;
    if (wr_mode) begin
      mode_nxt = {{(MODE_W-KEEP_W){1'b0}}, bus_wdata_i[KEEP_W-1:0]};
    end else begin
      if (rd_mode) begin
        mode_nxt[MB_HIT_TGT] = 1'b0;
        mode_nxt[MB_HIT_OVF] = 1'b0;
      end
      if (evt.tgt) begin
        mode_nxt[MB_HIT_TGT] = 1'b1;
        mode_nxt[MB_EVT]     = 1'b1;
      end
      if (evt.ovf) begin
        mode_nxt[MB_HIT_OVF] = 1'b1;
        mode_nxt[MB_EVT]     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      tgt_q  <= '0;
    end else begin
      mode_q <= mode_nxt;
      if (wr_tgt) tgt_q <= bus_wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_CNT:  bus_rdata_o[CNT_W-1:0]  = cnt_q;
      ADDR_MODE: bus_rdata_o[MODE_W-1:0] = mode_q;
      ADDR_TGT:  bus_rdata_o[CNT_W-1:0]  = tgt_q;
      default:   bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk import tmr_pkg::*; #(
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 32,
  parameter int INST_SEL = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic              bus_re_i,
  input logic [1:0]        bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [MODE_W-1:0] mode_q,
  input logic              tick,
  input logic              evt_tgt,
  input logic              evt_ovf
);
  assert_cnt_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == ADDR_CNT |=> cnt_q == $past(bus_wdata_i[CNT_W-1:0]));

  assert_rst_at_tgt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_tgt && mode_q[MB_RST_TGT] |=> cnt_q == '0);

  assert_one_shot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !mode_q[MB_RPT] |=> !irq_o);

  assert_mode_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == ADDR_MODE |=> cnt_q == '0 && !irq_o);

  assert_rd_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_re_i && !bus_we_i && bus_addr_i == ADDR_MODE && !evt_tgt && !evt_ovf
    |=> !mode_q[MB_HIT_TGT] && !mode_q[MB_HIT_OVF]);

  assert_evt_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> mode_q[MB_EVT]);

  assert_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (INST_SEL == 2) && mode_q[MB_STOP] && !bus_we_i |=> $stable(cnt_q));

  assert_tgt_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == ADDR_TGT && !tick |=> $stable(cnt_q));
endmodule

bind tgt_timer tmr_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .INST_SEL(INST_SEL)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_re_i    (bus_re_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .cnt_q       (cnt_q),
  .mode_q      (mode_q),
  .tick        (tick),
  .evt_tgt     (evt.tgt),
  .evt_ovf     (evt.ovf)
);

// File: tb/tgt_timer_tb_top.sv
`timescale 1ns/1ps
module tgt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        alt_tick = 1'b0;
  logic        a_we = 1'b0, a_re = 1'b0;
  logic [1:0]  a_addr = 2'd0;
  logic [31:0] a_wdata = '0;
  logic [31:0] a_rdata;
  logic        a_irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tgt_timer #(.INST_SEL(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .alt_tick_i(alt_tick), .irq_o(irq));

  tgt_timer #(.INST_SEL(1)) alt_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(a_we), .bus_re_i(a_re),
    .bus_addr_i(a_addr), .bus_wdata_i(a_wdata), .bus_rdata_o(a_rdata),
    .alt_tick_i(alt_tick), .irq_o(a_irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic count_irq(input int n, output int p);
    p = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) p++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    #1;
    check("R12 irq", {31'b0, irq}, 32'd0);
    addr = 2'd0; #1 check("R12 count", rdata, 32'd0);
    addr = 2'd1; #1 check("R12 mode", rdata, 32'd0);
    addr = 2'd2; #1 check("R12 target", rdata, 32'd0);
    rst_n = 1'b1;
    wait_cyc(2);
    addr = 2'd3; #1 check("R12 addr3", rdata, 32'd0);
    bus_rd(2'd1, v);
  endtask

  task automatic t_load();
    logic [31:0] v;
    bus_wr(2'd0, 32'hABCD_1234);
    bus_rd(2'd0, v);
    check("R1 truncated load", v, 32'h1234);
    wait_cyc(4);
    bus_rd(2'd0, v);
    check("R1 resume", v, 32'h1239);
  endtask

  task automatic t_free_run();
    logic [31:0] v;
    bus_wr(2'd1, 32'h0);
    wait_cyc(10);
    bus_rd(2'd0, v);
    check("R6 restart then count", v, 32'd10);
  endtask

  task automatic t_repeat();
    int p;
    logic [31:0] v;
    bus_wr(2'd2, 32'd5);
    bus_wr(2'd1, 32'h58);
    count_irq(20, p);
    check("R2/R5 repeat pulses", p, 32'd4);
    bus_rd(2'd0, v);
    check("R2 count below target", {31'b0, v < 32'd5}, 32'd1);
  endtask

  task automatic t_one_shot();
    int p;
    bus_wr(2'd2, 32'd3);
    bus_wr(2'd1, 32'h18);
    count_irq(20, p);
    check("R5 one-shot pulses", p, 32'd1);
    bus_wr(2'd1, 32'h18);
    count_irq(20, p);
    check("R5 re-armed pulses", p, 32'd1);
  endtask

  task automatic t_rd_clear();
    logic [31:0] v;
    bus_wr(2'd2, 32'd100);
    bus_wr(2'd1, 32'h10);
    wait_cyc(110);
    bus_rd(2'd1, v);
    check("R7 target flag", v, 32'h0C10);
    bus_rd(2'd1, v);
    check("R8 evt kept, R7 cleared", v, 32'h0410);
  endtask

  task automatic t_overflow();
    int p;
    logic [31:0] v;
    bus_wr(2'd2, 32'h100);
    bus_wr(2'd1, 32'h20);
    bus_wr(2'd0, 32'hFFF0);
    count_irq(20, p);
    check("R4 overflow pulses", p, 32'd1);
    bus_rd(2'd0, v);
    check("R3 wrapped count", v, 32'd4);
    bus_rd(2'd1, v);
    check("R3/R7 ovf flags", v, 32'h1420);
  endtask

  task automatic t_coincide();
    int p;
    logic [31:0] v;
    bus_wr(2'd2, 32'h0);
    bus_wr(2'd1, 32'h70);
    bus_wr(2'd0, 32'hFFFE);
    count_irq(4, p);
    check("R11 single pulse", p, 32'd1);
    bus_rd(2'd1, v);
    check("R11 both flags", v, 32'h1C70);
  endtask

  task automatic t_rd_vs_evt();
    logic [31:0] v;
    bus_wr(2'd2, 32'd10);
    bus_wr(2'd1, 32'h08);
    wait_cyc(9);
    bus_rd(2'd1, v);
    check("R7 read before event", v, 32'h0008);
    bus_rd(2'd1, v);
    check("R7 event wins over clear", v, 32'h0C08);
    bus_rd(2'd1, v);
    check("R7 later clear", v, 32'h0408);
  endtask

  task automatic t_tgt_write();
    logic [31:0] v, w;
    bus_wr(2'd2, 32'hF000);
    bus_wr(2'd1, 32'h0);
    wait_cyc(3);
    bus_rd(2'd0, v);
    bus_wr(2'd2, 32'h0077);
    bus_rd(2'd0, w);
    check("R10 count undisturbed", w, v + 32'd2);
    bus_rd(2'd2, w);
    check("R10 target stored", w, 32'h77);
  endtask

  task automatic t_div8();
    logic [31:0] v;
    bus_wr(2'd1, 32'h200);
    wait_cyc(7);
    bus_rd(2'd0, v);
    check("R9 div8 before first tick", v, 32'd0);
    wait_cyc(15);
    bus_rd(2'd0, v);
    check("R9 div8 two ticks", v, 32'd2);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    bus_wr(2'd1, 32'h1C01);
    bus_rd(2'd1, v);
    check("R6 upper mode bits dropped", v, 32'h0001);
    wait_cyc(10);
    bus_rd(2'd0, v);
    check("R9 stopped", v, 32'd0);
    bus_wr(2'd0, 32'h55);
    wait_cyc(5);
    bus_rd(2'd0, v);
    check("R9 stopped after load", v, 32'h55);
  endtask

  task automatic t_alt_tick();
    a_we = 1'b1; a_addr = 2'd1; a_wdata = 32'h100;
    @(negedge clk);
    a_we = 1'b0;
    for (int i = 0; i < 5; i++) begin
      alt_tick = 1'b1;
      @(negedge clk);
      alt_tick = 1'b0;
      wait_cyc(3);
    end
    a_re = 1'b1; a_addr = 2'd0;
    #1 check("R9 alt tick count", a_rdata, 32'd5);
    @(negedge clk);
    a_re = 1'b0;
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    t_load();
    t_free_run();
    t_repeat();
    t_one_shot();
    t_rd_clear();
    t_overflow();
    t_coincide();
    t_rd_vs_evt();
    t_tgt_write();
    t_div8();
    t_stop();
    t_alt_tick();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule